// File: doc/BRIEF.md
# Divisor Register Guard with Rollback

This block watches the write traffic that reaches one peripheral's counter and enforces a single safety rule: the counter's divisor register must not change while the counter is running. It decodes writes to the counter's control register, where bit 0 is the run flag, and writes to the divisor register. From these it keeps a copy of the run state and a shadow of the last divisor value that was written legitimately. When a divisor write lands while the counter is running, the block raises a request to write the shadowed value back. This undoes the illegal change. An external bus master carries out the write.

Requests leave through a single valid/ready slot. Further violations that occur while a request is still waiting merge into that request, because every such restore carries the same shadow value. The restoring write reappears on the observed bus. The block recognises it as its own echo and does not treat it as a fresh violation. A legitimate divisor write, made while the counter is stopped, withdraws any restore that has not yet been accepted, so a stale value cannot overwrite the new one.

Top module: `divreg_guard`

## Requirements
- R1: After reset, no request is pending, the counter is considered stopped, and the shadow divisor value is 0.
- R2: A write to base+0x220 sets the run state to data bit 0: 1 means running, 0 means stopped. The other data bits have no effect.
- R3: A write to base+0x228 while stopped is legitimate. It raises no request, and its low 16 bits become the new shadow value.
- R4: A write to base+0x228 while running raises a request with rq_addr = base+0x228, rq_data = shadow value and rq_bytes = 2. rq_valid is low one clock edge after the edge that samples the write and high after the second edge.
- R5: A write that is rolled back does not change the shadow value.
- R6: A pending request keeps rq_valid, rq_addr and rq_data stable until rq_ready is seen high at a clock edge. Violations made while it waits merge into it. After acceptance, a new violation raises a new request.
- R7: A divisor write whose value equals the shadow value is consumed as an echo when at least one accepted restore has not yet been seen. An echo raises no request and is never a violation. The number of outstanding echoes saturates at 3.
- R8: A legitimate divisor write withdraws a pending request that has not been accepted: rq_valid drops after the next edge.
- R9: Cycles with bus_wr low, and writes to any other address, leave the requests and the run state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_addr | input | 32 | Base address assigned to the peripheral |
| bus_wr | input | 1 | An observed write is present this cycle |
| bus_addr | input | 32 | Address of the observed write |
| bus_data | input | 32 | Data of the observed write |
| rq_valid | output | 1 | Restore request pending |
| rq_ready | input | 1 | The master takes the request at this edge |
| rq_addr | output | 32 | Address to restore (base+0x228) |
| rq_data | output | 16 | Divisor value to write back |
| rq_bytes | output | 4 | Byte count of the restore write (2) |

## Verification
The assertions check on every cycle the relationships that are local in time. They cover these points: a control write sets the run state, a legitimate write loads the shadow and a violation leaves it alone, a violation raises a request on the next edge, and a waiting request keeps its valid, address and data stable. A withdrawal clears the slot. Some behaviour only shows over a sequence of writes and acceptances, and only the bench's scenarios exercise it: echo recognition against restores that were accepted earlier, saturation of the outstanding-echo count, the interplay between withdrawal and later echoes, and the exact two-edge latency. The bench sweeps every run state, divisor values 0 to 7 and both accept choices against an arithmetic model.

// File: rtl/divg_pkg.sv
package divg_pkg;
  // kind of observed write after address decode
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_CTRL = 2'd1,
    EV_DIV  = 2'd2
  } ev_kind_e;

  // what the guard does with a decoded event
  typedef enum logic [2:0] {
    ACT_IDLE  = 3'd0,
    ACT_CTRL  = 3'd1,
    ACT_LEGIT = 3'd2,
    ACT_ECHO  = 3'd3,
    ACT_VIOL  = 3'd4
  } act_e;
endpackage

// File: rtl/divg_decode.sv
module divg_decode
  import divg_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int CTRL_OFS = 'h220,
  parameter int DIV_OFS  = 'h228
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output ev_kind_e          ev_kind,
  output logic [DATA_W-1:0] ev_data
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] DIV_A  = ADDR_W'(DIV_OFS);

  ev_kind_e kind_d;

  always_comb begin
    kind_d = EV_NONE;
    if (bus_wr) begin
      if (bus_addr == base_addr + CTRL_A)     kind_d = EV_CTRL;
      else if (bus_addr == base_addr + DIV_A) kind_d = EV_DIV;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_kind <= EV_NONE;
      ev_data <= '0;
    end else begin
      ev_kind <= kind_d;
      ev_data <= bus_data;
    end
  end

  // R9
  idle_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> ev_kind == EV_NONE);
endmodule

// File: rtl/divg_guard.sv
module divg_guard
  import divg_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int ECHO_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  ev_kind_e         ev_kind,
  input  logic [DIV_W-1:0] ev_div,
  input  logic             ev_run,
  input  logic             accept,
  output logic             running,
  output logic [DIV_W-1:0] shadow,
  output logic             trig,
  output logic             retract
);
  localparam logic [ECHO_W-1:0] ECHO_MAX = '1;

  logic [ECHO_W-1:0] echo_q;
  act_e act;

  always_comb begin
    act = ACT_IDLE;
    case (ev_kind)
      EV_CTRL: act = ACT_CTRL;
      EV_DIV: begin
        if (echo_q != '0 && ev_div == shadow) act = ACT_ECHO;
        else if (running)                     act = ACT_VIOL;
        else                                  act = ACT_LEGIT;
      end
      default: act = ACT_IDLE;
    endcase
  end

  assign trig    = (act == ACT_VIOL);
  assign retract = (act == ACT_LEGIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      shadow  <= '0;
      echo_q  <= '0;
    end else begin
      if (act == ACT_CTRL)  running <= ev_run;
      if (act == ACT_LEGIT) shadow  <= ev_div;
      if (accept && act != ACT_ECHO && echo_q != ECHO_MAX)
        echo_q <= echo_q + 1'b1;
      else if (!accept && act == ACT_ECHO)
        echo_q <= echo_q - 1'b1;
    end
  end

  // R2
  run_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ev_kind == EV_CTRL |=> running == $past(ev_run));
  // R3
  shadow_load_chk: assert property (@(posedge clk) disable iff (rst)
    retract |=> shadow == $past(ev_div));
  // R5
  shadow_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_kind == EV_DIV && running) |=> $stable(shadow));
  // R4
  viol_running_chk: assert property (@(posedge clk) disable iff (rst)
    trig |-> running && ev_kind == EV_DIV);
endmodule

// File: rtl/divg_request.sv
module divg_request #(
  parameter int ADDR_W = 32,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic              retract,
  input  logic [DIV_W-1:0]  shadow,
  input  logic [ADDR_W-1:0] div_addr,
  input  logic              rq_ready,
  output logic              rq_valid,
  output logic [ADDR_W-1:0] rq_addr,
  output logic [DIV_W-1:0]  rq_data
);
  logic slot_free;
  assign slot_free = !rq_valid || rq_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rq_valid <= 1'b0;
      rq_addr  <= '0;
      rq_data  <= '0;
    end else if (retract) begin
      rq_valid <= 1'b0;
    end else if (trig) begin
      rq_valid <= 1'b1;
      if (slot_free) begin
        rq_addr <= div_addr;
        rq_data <= shadow;
      end
    end else if (rq_valid && rq_ready) begin
      rq_valid <= 1'b0;
    end
  end

  // R4
  trig_raise_chk: assert property (@(posedge clk) disable iff (rst)
    trig |=> rq_valid);
  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (rq_valid && !rq_ready && !retract) |=> rq_valid && $stable(rq_data) && $stable(rq_addr));
  // R8
  withdraw_chk: assert property (@(posedge clk) disable iff (rst)
    retract |=> !rq_valid);
endmodule

// File: rtl/divreg_guard.sv
module divreg_guard
  import divg_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int DIV_W    = 16,
  parameter int CTRL_OFS = 'h220,
  parameter int DIV_OFS  = 'h228,
  parameter int ECHO_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              rq_valid,
  input  logic              rq_ready,
  output logic [ADDR_W-1:0] rq_addr,
  output logic [DIV_W-1:0]  rq_data,
  output logic [3:0]        rq_bytes
);
  localparam logic [ADDR_W-1:0] DIV_A = ADDR_W'(DIV_OFS);

  ev_kind_e          ev_kind;
  logic [DATA_W-1:0] ev_data;
  logic              running;
  logic [DIV_W-1:0]  shadow;
  logic              trig;
  logic              retract;
  logic              accept;

  assign accept   = rq_valid && rq_ready;
  assign rq_bytes = 4'(DIV_W / 8);

  divg_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFS(CTRL_OFS), .DIV_OFS(DIV_OFS)
  ) u_dec (
    .clk(clk), .rst(rst), .base_addr(base_addr), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_data(bus_data),
    .ev_kind(ev_kind), .ev_data(ev_data)
  );

  divg_guard #(.DIV_W(DIV_W), .ECHO_W(ECHO_W)) u_grd (
    .clk(clk), .rst(rst), .ev_kind(ev_kind), .ev_div(ev_data[DIV_W-1:0]),
    .ev_run(ev_data[0]), .accept(accept), .running(running),
    .shadow(shadow), .trig(trig), .retract(retract)
  );

  divg_request #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_req (
    .clk(clk), .rst(rst), .trig(trig), .retract(retract), .shadow(shadow),
    .div_addr(base_addr + DIV_A), .rq_ready(rq_ready),
    .rq_valid(rq_valid), .rq_addr(rq_addr), .rq_data(rq_data)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !rq_valid && !running);
endmodule

// File: tb/divreg_guard_test.sv
module divreg_guard_test;
  localparam int CLK_P = 10;
  localparam logic [31:0] BASE = 32'h0004_0000;
  localparam logic [31:0] A_CTRL = BASE + 32'h220;
  localparam logic [31:0] A_DIV  = BASE + 32'h228;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_data = '0;
  logic        rq_ready = 1'b0;
  logic        rq_valid;
  logic [31:0] rq_addr;
  logic [15:0] rq_data;
  logic [3:0]  rq_bytes;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  bit          m_run = 0;
  bit          m_pend = 0;
  logic [15:0] m_shadow = '0;
  logic [15:0] m_rqdata = '0;
  int          m_echo = 0;

  always #(CLK_P/2) clk = ~clk;

  divreg_guard uut (
    .clk(clk), .rst(rst), .base_addr(BASE), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_data(bus_data), .rq_valid(rq_valid),
    .rq_ready(rq_ready), .rq_addr(rq_addr), .rq_data(rq_data),
    .rq_bytes(rq_bytes)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic mdl(input logic [31:0] a, input logic [31:0] d);
    if (a == A_CTRL) m_run = d[0];
    else if (a == A_DIV) begin
      if (m_echo > 0 && d[15:0] == m_shadow) m_echo--;
      else if (m_run) begin
        if (!m_pend) m_rqdata = m_shadow;
        m_pend = 1;
      end else begin
        m_shadow = d[15:0];
        m_pend = 0;
      end
    end
  endtask

  task automatic cmp(input string tag);
    check(tag, rq_valid, m_pend);
    if (m_pend) begin
      check(tag, rq_data, m_rqdata);
      check(tag, rq_addr, A_DIV);
      check(tag, rq_bytes, 4'd2);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_data = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = '0; bus_data = '0;
    @(negedge clk);
    mdl(a, d);
    cmp(tag);
  endtask

  task automatic acc(input string tag);
    @(negedge clk);
    rq_ready = 1'b1;
    @(negedge clk);
    rq_ready = 1'b0;
    if (m_pend) begin
      m_pend = 0;
      if (m_echo < 3) m_echo++;
    end
    cmp(tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle", rq_valid, 1'b0);

    // R1: stopped after reset, so this write is legitimate (R3)
    wr(A_DIV, 32'h0009, "R1 R3 legit after reset");
    wr(A_CTRL, 32'h1, "R2 start");

    // R4 exact latency
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_DIV; bus_data = 32'h0005;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R4 one edge", rq_valid, 1'b0);
    @(negedge clk);
    mdl(A_DIV, 32'h0005);
    check("R4 two edges", rq_valid, 1'b1);
    cmp("R4 request");

    // R6 merge and hold
    wr(A_DIV, 32'h0006, "R6 merge");
    repeat (4) @(negedge clk);
    cmp("R6 hold");
    check("R5 data kept", rq_data, 16'h0009);
    acc("R6 accept");

    // R7 echo consumed, then same value again is a violation
    wr(A_DIV, 32'h0009, "R7 echo");
    wr(A_DIV, 32'h0009, "R4 after echo");
    acc("R6 accept 2");

    // R8 withdrawal by a legitimate write
    wr(A_DIV, 32'h0004, "R4 viol");
    wr(A_CTRL, 32'h0, "R2 stop");
    wr(A_DIV, 32'h0007, "R8 withdraw");
    check("R8 dropped", rq_valid, 1'b0);

    // R9 ignored traffic
    wr(A_CTRL, 32'h1, "R2 start");
    wr(BASE + 32'h224, 32'h1234, "R9 other addr");
    wr(BASE + 32'h229, 32'h1234, "R9 near addr");
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = A_DIV; bus_data = 32'h0042;
    @(negedge clk);
    bus_addr = '0;
    @(negedge clk);
    cmp("R9 no strobe");
    wr(A_CTRL, 32'hFFFF_FFFE, "R2 bit0 only");
    wr(A_DIV, 32'h0003, "R9 R2 still stopped");

    // sweep run state x divisor value x accept choice
    for (int e = 0; e < 2; e++)
      for (int d = 0; d < 8; d++)
        for (int k = 0; k < 2; k++) begin
          string tg;
          wr(A_CTRL, 32'(e), "R2 sweep");
          if (m_echo > 0 && 16'(d) == m_shadow) tg = "R7 sweep";
          else if (m_run) tg = "R4 R5 sweep";
          else tg = "R3 R8 sweep";
          wr(A_DIV, 32'(d), tg);
          if (k == 1) acc("R6 sweep");
        end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule